// File: doc/BRIEF.md
# Power-Stage Reset Sequencer

This controller sits beside a PWM modulator and owns the active-low reset of a switching output stage. The stage has to come up in its high-impedance state. It may only leave that state once its bootstrap capacitors have had time to charge from the gate-drive supply, and only while the modulator is actually sending a clean switching stream. Driving the reset high with a stuck or unknown PWM level would leave a high-side transistor on until its bootstrap charge runs out.

The block counts a programmable charge wait from the moment the supply-good flag rises. It restarts that wait whenever the flag drops. It also measures every rising-edge-to-rising-edge period of the PWM stream in system clocks, and it releases the stage reset only after a run of consecutive periods has landed inside the allowed window. It also drives a PWM-enable that gates the stream towards the stage. On a power-down request, a modulator drop or a supply drop, it lowers the stage reset first. It then keeps the stream enabled for a programmable hold time, so the stage is already quiet before the PWM stops.

The PWM input is assumed to be synchronous to the system clock. The block has one synchronous active-low reset.

Top module: `pstage_rst_seq`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `stage_rst_n` and `pwm_en` are both 0.
- R2: `pwm_en` and `stage_rst_n` stay 0 until `supply_ok` has been sampled high on CHARGE_CYC consecutive clock edges. Any low sample restarts the count from zero.
- R3: Once charged, with `mod_ready` high and `pwr_down_req` low, `pwm_en` rises one clock later. `stage_rst_n` stays 0 at that point.
- R4: A PWM period is the number of clock edges from one sampled rising edge of `pwm_in` to the next. `stage_rst_n` rises one clock after LOCK_CNT consecutive periods each in [PER_MIN, PER_MAX] have completed. The limits PER_MIN and PER_MAX are themselves valid.
- R5: A period shorter than PER_MIN or longer than PER_MAX resets the run of good periods. If `stage_rst_n` is high, it drops one clock after the bad period is detected, and `pwm_en` stays 1.
- R6: A PWM held at a constant level (high or low) is invalid. `stage_rst_n` falls one clock after PER_MAX edges pass with no new rising edge.
- R7: `stage_rst_n` is never 1 unless `pwm_en` is 1 and `mod_ready` was high on the previous edge.
- R8: On `pwr_down_req`, `stage_rst_n` falls one clock later. `pwm_en` then stays 1 for exactly PD_HOLD more clocks before it falls.
- R9: While `pwr_down_req` is held, `stage_rst_n` and `pwm_en` stay 0 even with a valid PWM. After release, the block re-arms and releases reset without a new charge wait.
- R10: Dropping `mod_ready` while running gives the same ordered shutdown as R8.
- R11: Dropping `supply_ok` while running gives the same ordered shutdown as R8, and a full new charge wait is then required (R2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| supply_ok | input | 1 | Gate-drive supply is within range |
| mod_ready | input | 1 | Modulator is initialised and streaming |
| pwm_in | input | 1 | PWM stream sent to the stage, synchronous to clk |
| pwr_down_req | input | 1 | Request an ordered shutdown of the stage |
| stage_rst_n | output | 1 | Active-low reset to the output stage |
| pwm_en | output | 1 | Gate that passes the PWM stream to the stage |

## Verification
The bench builds the block with CHARGE_CYC=40, PER_MIN=8, PER_MAX=12, LOCK_CNT=4 and PD_HOLD=5. A lock attempt then takes a few dozen clocks and a full charge wait takes only 40. With these values, random periods drawn from 4 to 16 fall on both sides of each window edge. The 7/8 and 12/13 boundaries are also hit directly, and stuck levels, out-of-window periods and every shutdown cause are reached in a few hundred cycles. A small PD_HOLD keeps the exact enable-fall cycle easy to count.

// File: rtl/pstage_pkg.sv
`timescale 1ns/1ps
// Shared types for the power-stage reset sequencer.
package pstage_pkg;

    // Sequencer states: stage off, PWM gated in, stage running, ordered shutdown.
    typedef enum logic [1:0] {
        ST_HIZ   = 2'd0,
        ST_ARM   = 2'd1,
        ST_RUN   = 2'd2,
        ST_DRAIN = 2'd3
    } seq_state_t;

endpackage

// File: rtl/pstage_charge_timer.sv
`timescale 1ns/1ps
// Bootstrap charge timer.
// Counts consecutive clock edges with supply_ok high and saturates at CHARGE_CYC.
// charged is high once the full count is reached. Any low sample clears the count.
// Assumes supply_ok is already synchronous to clk.
module pstage_charge_timer #(
    parameter int CHARGE_CYC = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    output logic charged
);
    localparam int CW = $clog2(CHARGE_CYC + 1);
    localparam logic [CW-1:0] CMAX = CW'(CHARGE_CYC);

    logic [CW-1:0] cnt_q;

    // Saturating count of supply-good time, restarted on any drop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!supply_ok) begin
            cnt_q <= '0;
        end else if (cnt_q != CMAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign charged = (cnt_q == CMAX);

endmodule

// File: rtl/pstage_pwm_monitor.sv
`timescale 1ns/1ps
// PWM stream monitor.
// Measures rising-edge-to-rising-edge periods in clock edges. pwm_valid rises after
// LOCK_CNT consecutive periods in [PER_MIN, PER_MAX]. A period outside the window
// clears the run. If PER_MAX edges pass with no rise, the stream counts as stuck:
// the run is cleared and the monitor waits for a fresh reference edge.
// Assumes pwm_in is synchronous to clk.
module pstage_pwm_monitor #(
    parameter int PER_MIN  = 250,
    parameter int PER_MAX  = 286,
    parameter int LOCK_CNT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_in,
    output logic pwm_valid
);
    localparam int PW = $clog2(PER_MAX + 1);
    localparam int LW = $clog2(LOCK_CNT + 1);
    localparam logic [PW-1:0] PMIN = PW'(PER_MIN);
    localparam logic [PW-1:0] PMAX = PW'(PER_MAX);
    localparam logic [LW-1:0] LMAX = LW'(LOCK_CNT);

    logic          pwm_q;
    logic          seen_q;
    logic [PW-1:0] per_q;
    logic [LW-1:0] good_q;
    logic          rise;
    logic          in_win;

    assign rise   = pwm_in && !pwm_q;
    assign in_win = (per_q >= PMIN) && (per_q <= PMAX);

    // Period measurement, window test and run-length count of good periods.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_q  <= 1'b0;
            seen_q <= 1'b0;
            per_q  <= '0;
            good_q <= '0;
        end else begin
            pwm_q <= pwm_in;
            if (rise) begin
                if (seen_q) begin
                    if (!in_win)
                        good_q <= '0;
                    else if (good_q != LMAX)
                        good_q <= good_q + 1'b1;
                end
                seen_q <= 1'b1;
                per_q  <= PW'(1);
            end else if (seen_q) begin
                if (per_q == PMAX) begin
                    seen_q <= 1'b0;
                    good_q <= '0;
                end else begin
                    per_q <= per_q + 1'b1;
                end
            end
        end
    end

    assign pwm_valid = (good_q == LMAX);

endmodule

// File: rtl/pstage_seq_fsm.sv
`timescale 1ns/1ps
// Reset sequencing state machine.
// HIZ: stage reset low, PWM gated off. ARM: PWM passed through, reset still low.
// RUN: reset released. DRAIN: reset low again, PWM kept for PD_HOLD clocks.
// Outputs are decoded from the registered state only.
// Assumes all inputs are synchronous to clk.
module pstage_seq_fsm
    import pstage_pkg::*;
#(
    parameter int PD_HOLD = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ready,
    input  logic mod_ready,
    input  logic pwm_valid,
    input  logic pd_req,
    output logic stage_rst_n,
    output logic pwm_en
);
    localparam int DW = $clog2(PD_HOLD + 1);
    localparam logic [DW-1:0] DLAST = DW'(PD_HOLD - 1);

    seq_state_t    state_q, state_d;
    logic [DW-1:0] drain_q;
    logic          go_ok;

    assign go_ok = ready && mod_ready && !pd_req;

    // Next-state selection; shutdown causes take priority over PWM loss.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HIZ:   if (go_ok) state_d = ST_ARM;
            ST_ARM: begin
                if (!go_ok)         state_d = ST_HIZ;
                else if (pwm_valid) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!go_ok)          state_d = ST_DRAIN;
                else if (!pwm_valid) state_d = ST_ARM;
            end
            ST_DRAIN: if (drain_q == DLAST) state_d = ST_HIZ;
            default:  state_d = ST_HIZ;
        endcase
    end

    // State register and drain hold counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HIZ;
            drain_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != ST_DRAIN)
                drain_q <= '0;
            else
                drain_q <= drain_q + 1'b1;
        end
    end

    assign stage_rst_n = (state_q == ST_RUN);
    assign pwm_en      = (state_q != ST_HIZ);

endmodule

// File: rtl/pstage_rst_seq.sv
`timescale 1ns/1ps
// Power-stage reset sequencer, top level.
// Joins the charge timer, the PWM monitor and the sequencing state machine.
// The stage reset is released only after the charge wait and a verified PWM
// lock. It is always lowered before the PWM enable on the way down.
// Assumes every input is synchronous to clk.
module pstage_rst_seq #(
    parameter int CHARGE_CYC = 100000,
    parameter int PER_MIN    = 250,
    parameter int PER_MAX    = 286,
    parameter int LOCK_CNT   = 16,
    parameter int PD_HOLD    = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic mod_ready,
    input  logic pwm_in,
    input  logic pwr_down_req,
    output logic stage_rst_n,
    output logic pwm_en
);
    logic charged;
    logic pwm_valid;
    logic ready;

    // Supply counts as ready only when it is good now and has been long enough.
    assign ready = supply_ok && charged;

    pstage_charge_timer #(.CHARGE_CYC(CHARGE_CYC)) u_charge (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_ok (supply_ok),
        .charged   (charged)
    );

    pstage_pwm_monitor #(
        .PER_MIN  (PER_MIN),
        .PER_MAX  (PER_MAX),
        .LOCK_CNT (LOCK_CNT)
    ) u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwm_in    (pwm_in),
        .pwm_valid (pwm_valid)
    );

    pstage_seq_fsm #(.PD_HOLD(PD_HOLD)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ready       (ready),
        .mod_ready   (mod_ready),
        .pwm_valid   (pwm_valid),
        .pd_req      (pwr_down_req),
        .stage_rst_n (stage_rst_n),
        .pwm_en      (pwm_en)
    );

endmodule

// File: rtl/pstage_rst_seq_chk.sv
`timescale 1ns/1ps
// Property checker for the power-stage reset sequencer, bound to the top.
// Keeps its own count of supply-good time and of clocks since the last PWM rise.
module pstage_rst_seq_chk #(
    parameter int CHARGE_CYC = 100000,
    parameter int PER_MAX    = 286
) (
    input logic clk,
    input logic rst_n,
    input logic supply_ok,
    input logic mod_ready,
    input logic pwm_in,
    input logic pwr_down_req,
    input logic stage_rst_n,
    input logic pwm_en
);
    localparam int SW = $clog2(CHARGE_CYC + 2);
    localparam int GW = $clog2(PER_MAX + 2);
    localparam logic [SW-1:0] SMAX = SW'(CHARGE_CYC + 1);
    localparam logic [GW-1:0] GMAX = GW'(PER_MAX + 1);

    logic [SW-1:0] sup_run;
    logic [GW-1:0] gap;
    logic          pwm_d;

    // Independent saturating counts of supply-good time and of clocks since a PWM rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sup_run <= '0;
            gap     <= '0;
            pwm_d   <= 1'b0;
        end else begin
            pwm_d <= pwm_in;
            if (!supply_ok)      sup_run <= '0;
            else if (sup_run != SMAX) sup_run <= sup_run + 1'b1;
            if (pwm_in && !pwm_d) gap <= '0;
            else if (gap != GMAX) gap <= gap + 1'b1;
        end
    end

    AST_RST_NEEDS_CHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        stage_rst_n |-> (sup_run >= SW'(CHARGE_CYC))); // R2

    AST_RST_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        stage_rst_n |-> pwm_en); // R7

    AST_RST_NEEDS_MOD_READY: assert property (@(posedge clk) disable iff (!rst_n)
        stage_rst_n |-> $past(mod_ready)); // R7

    AST_PD_RST_LOW_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_down_req && stage_rst_n) |=> !stage_rst_n); // R8

    AST_EN_FALLS_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwm_en) |-> (!stage_rst_n && !$past(stage_rst_n))); // R8

    AST_NO_RUN_ON_STUCK: assert property (@(posedge clk) disable iff (!rst_n)
        stage_rst_n |-> (gap <= GW'(PER_MAX))); // R6

endmodule

bind pstage_rst_seq pstage_rst_seq_chk #(
    .CHARGE_CYC (CHARGE_CYC),
    .PER_MAX    (PER_MAX)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .supply_ok    (supply_ok),
    .mod_ready    (mod_ready),
    .pwm_in       (pwm_in),
    .pwr_down_req (pwr_down_req),
    .stage_rst_n  (stage_rst_n),
    .pwm_en       (pwm_en)
);

// File: tb/pstage_rst_seq_tb_top.sv
`timescale 1ns/1ps
// Bench for the power-stage reset sequencer: directed corners plus seeded random periods.
module pstage_rst_seq_tb_top;
    localparam int CHG  = 40;
    localparam int PMIN = 8;
    localparam int PMAX = 12;
    localparam int LOCK = 4;
    localparam int HOLD = 5;

    logic clk = 1'b0;
    logic rst_n, supply_ok, mod_ready, pwm_in, pwr_down_req;
    logic stage_rst_n, pwm_en;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    always #2.5 clk = ~clk;

    pstage_rst_seq #(
        .CHARGE_CYC (CHG),
        .PER_MIN    (PMIN),
        .PER_MAX    (PMAX),
        .LOCK_CNT   (LOCK),
        .PD_HOLD    (HOLD)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .supply_ok    (supply_ok),
        .mod_ready    (mod_ready),
        .pwm_in       (pwm_in),
        .pwr_down_req (pwr_down_req),
        .stage_rst_n  (stage_rst_n),
        .pwm_en       (pwm_en)
    );

    function automatic bit in_window(int p);
        return (p >= PMIN) && (p <= PMAX);
    endfunction

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // Each period: one clock high, then p-1 clocks low.
    task automatic pwm_periods(int n, int p);
        for (int i = 0; i < n; i++) begin
            pwm_in = 1'b1; tick(1);
            pwm_in = 1'b0; tick(p - 1);
        end
    endtask

    // Fresh lock attempt with period p; reset must rise exactly when expected.
    task automatic try_lock(int p, string req);
        bit exp = in_window(p);
        pwm_in = 1'b0; tick(PMAX + 2);
        pwm_periods(LOCK, p);
        chk(req, stage_rst_n, 1'b0);
        pwm_in = 1'b1; tick(1);
        chk(req, stage_rst_n, 1'b0);
        pwm_in = 1'b0; tick(1);
        chk(req, stage_rst_n, exp);
        tick(p - 2);
    endtask

    initial begin
        void'($urandom(32'd20250917));
        rst_n = 1'b0; supply_ok = 1'b0; mod_ready = 1'b0; pwm_in = 1'b0; pwr_down_req = 1'b0;
        tick(3);
        chk("R1 rst", stage_rst_n, 1'b0);
        chk("R1 en", pwm_en, 1'b0);
        rst_n = 1'b1; tick(1);
        chk("R1 after", pwm_en, 1'b0);

        // R2: interrupted charge restarts the wait.
        mod_ready = 1'b1; supply_ok = 1'b1; tick(20);
        supply_ok = 1'b0; tick(1);
        supply_ok = 1'b1; tick(CHG);
        chk("R2 wait", pwm_en, 1'b0);
        tick(1);
        chk("R3 en", pwm_en, 1'b1);
        chk("R3 rst", stage_rst_n, 1'b0);

        // R4: nominal and boundary periods, R5 out of window.
        try_lock(10, "R4 p10");
        try_lock(PMIN, "R4 pmin");
        try_lock(PMAX, "R4 pmax");
        try_lock(PMIN - 1, "R5 short");
        try_lock(PMAX + 1, "R5 long");

        // R5: short period while running.
        try_lock(10, "R4 relock");
        pwm_periods(1, 6);
        pwm_in = 1'b1; tick(1);
        chk("R5 run short", stage_rst_n, 1'b1);
        pwm_in = 1'b0; tick(1);
        chk("R5 run short", stage_rst_n, 1'b0);
        chk("R5 en kept", pwm_en, 1'b1);

        // R5: long period while running.
        try_lock(10, "R4 relock");
        pwm_periods(1, PMAX + 1);
        chk("R5 run long", stage_rst_n, 1'b1);
        tick(1);
        chk("R5 run long", stage_rst_n, 1'b0);

        // R6: stuck high.
        try_lock(10, "R4 relock");
        pwm_in = 1'b1; tick(PMAX + 1);
        chk("R6 stuck", stage_rst_n, 1'b1);
        tick(1);
        chk("R6 stuck", stage_rst_n, 1'b0);
        pwm_in = 1'b0;

        // R8: ordered power-down.
        try_lock(10, "R4 relock");
        pwr_down_req = 1'b1; tick(1);
        chk("R8 rst", stage_rst_n, 1'b0);
        chk("R8 en", pwm_en, 1'b1);
        tick(HOLD - 1);
        chk("R8 hold", pwm_en, 1'b1);
        tick(1);
        chk("R8 off", pwm_en, 1'b0);

        // R9: held request blocks release; release re-arms without charge wait.
        pwm_periods(LOCK + 2, 10);
        chk("R9 rst", stage_rst_n, 1'b0);
        chk("R9 en", pwm_en, 1'b0);
        pwr_down_req = 1'b0;
        pwm_periods(1, 10);
        chk("R9 rerun", stage_rst_n, 1'b1);

        // R10: modulator drop while running.
        mod_ready = 1'b0; tick(1);
        chk("R10 rst", stage_rst_n, 1'b0);
        chk("R10 en", pwm_en, 1'b1);
        tick(HOLD);
        chk("R10 off", pwm_en, 1'b0);
        mod_ready = 1'b1;

        // R11: supply drop while running, then a full new charge wait.
        try_lock(10, "R4 relock");
        supply_ok = 1'b0; tick(1);
        chk("R11 rst", stage_rst_n, 1'b0);
        chk("R11 en", pwm_en, 1'b1);
        supply_ok = 1'b1; tick(HOLD);
        chk("R11 off", pwm_en, 1'b0);
        tick(CHG - HOLD);
        chk("R11 recharge", pwm_en, 1'b0);
        tick(1);
        chk("R11 rearm", pwm_en, 1'b1);

        // R4/R5 random periods straddling both window edges.
        for (int k = 0; k < 16; k++) begin
            int p = $urandom_range(16, 4);
            try_lock(p, in_window(p) ? "R4 rand" : "R5 rand");
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule